// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block produces the byte that a parallel NOR-style flash device puts on its data bus when the host reads it while the internal program/erase engine is busy. A compact state machine follows the engine through its phases. Each read strobe then builds a fresh status byte from four inputs: the current phase, the block being read, the set of blocks selected for erase, and the top bit of the byte being programmed. No stored status register exists. Two of the bits are toggle flip-flops that advance on each read, so a host can poll for completion by comparing successive reads.

The states are `ST_IDLE` (reads return array data), `ST_PROG` (program running), `ST_EWIN` (block-erase collection window), `ST_ERASE` (erase running), `ST_SUSP` (erase suspended) and `ST_FAULT` (operation failed). The transitions are:
- IDLE→PROG on a program command.
- IDLE→EWIN on a block-erase command.
- IDLE→ERASE on a chip-erase command.
- EWIN→ERASE when the window counter runs out.
- PROG→IDLE and ERASE→IDLE on the done pulse.
- PROG→FAULT and ERASE→FAULT on the fail pulse.
- ERASE→SUSP on suspend. This applies to block erase only.
- SUSP→ERASE on resume.
- FAULT→IDLE on the read/reset command.

A synchronous reset returns the block to IDLE from any state. The cell array is simulated outside the block. It supplies done and fail pulses, plus the array byte for the address being read.

Top module: `flash_status_unit`

## Requirements
- R1: After reset, `dq` is 0x00. In IDLE, a read returns `arr_data` unchanged.
- R2: In PROG, a read returns bit 7 equal to the inverse of `prog_d7`, with bits 5 and 3 at 0.
- R3: In EWIN, ERASE and an erase-type FAULT, bit 7 reads 0. In SUSP, a read of a block in the erase set returns bit 7 = 1 and bit 3 = 1.
- R4: In SUSP, a read of a block outside the erase set returns `arr_data` unchanged.
- R5: Bit 6 inverts on every read in PROG, EWIN, ERASE and FAULT. It keeps its previous value on reads in SUSP.
- R6: Bit 5 reads 1 only in FAULT, which is entered on `op_fail` in PROG or ERASE. FAULT is left only by `cmd_reset` or reset. After leaving it, reads return array data.
- R7: Bit 3 reads 0 in EWIN and 1 in ERASE, SUSP and erase-type FAULT. EWIN lasts WIN_CYC cycles after the most recent block-erase command, so each further block-erase command in EWIN adds its block and restarts the count. Chip erase enters ERASE directly.
- R8: Bit 2 inverts on a read only when the read block is in the erase set, in EWIN, ERASE, SUSP or erase-type FAULT. Otherwise it keeps its value. Chip erase puts every block in the set.
- R9: Bits 4, 1 and 0 read 0 whenever a status byte, rather than array data, is returned.
- R10: The following are ignored:
  - erase commands while in PROG;
  - `op_done` while in SUSP;
  - `cmd_suspend` during a chip erase.
- R11: `dq` changes only in the cycle after a rising edge of `rd_stb`. Holding `rd_stb` high for several cycles counts as one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_prog | input | 1 | Program command pulse |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed, taken with `cmd_prog` |
| cmd_blk_erase | input | 1 | Block-erase command pulse |
| cmd_blk | input | BLK_BITS | Block addressed by a block-erase command |
| cmd_chip_erase | input | 1 | Chip-erase command pulse |
| cmd_suspend | input | 1 | Erase-suspend command pulse |
| cmd_resume | input | 1 | Erase-resume command pulse |
| cmd_reset | input | 1 | Read/reset command pulse; clears FAULT |
| op_done | input | 1 | Operation-complete pulse from the array |
| op_fail | input | 1 | Operation-failed pulse from the array |
| rd_stb | input | 1 | Read strobe; a rising edge is one read |
| rd_blk | input | BLK_BITS | Block of the address being read |
| arr_data | input | 8 | Array byte at the address being read |
| dq | output | 8 | Byte returned for the latest read |

## Verification
The bench builds the block with WIN_CYC = 8 and BLK_BITS = 3, which gives eight blocks. The short window lets the bench do three things:
- enter a second block-erase command after five idle cycles;
- read a few cycles later, in a cycle that would already be in ERASE without the restart;
- wait past the window and see bit 3 rise.

With eight blocks, the bench can read from blocks inside and outside a two-block erase set. It can then compare those reads with a chip erase, where every block is in the set.

// File: rtl/flsts_pkg.sv
package flsts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_EWIN,
        ST_ERASE,
        ST_SUSP,
        ST_FAULT
    } fsm_e;

    localparam int BUS_W = 8;

endpackage

// File: rtl/flsts_win_timer.sv
module flsts_win_timer #(
    parameter int WIN_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(WIN_CYC - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && !load && (cnt_q == '0);

endmodule

// File: rtl/flsts_erase_map.sv
module flsts_erase_map #(
    parameter int BLK_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                first,
    input  logic                add,
    input  logic                set_all,
    input  logic [BLK_BITS-1:0] cmd_blk,
    input  logic [BLK_BITS-1:0] rd_blk,
    output logic                hit
);
    localparam int NBLK = 1 << BLK_BITS;

    logic [NBLK-1:0] sel_q;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic match;
        assign match = (cmd_blk == BLK_BITS'(b));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[b] <= 1'b0;
            end else if (set_all) begin
                sel_q[b] <= 1'b1;
            end else if (first) begin
                sel_q[b] <= match;
            end else if (add && match) begin
                sel_q[b] <= 1'b1;
            end
        end
    end

    assign hit = sel_q[rd_blk];

endmodule

// File: rtl/flsts_toggle.sv
module flsts_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import flsts_pkg::*;
#(
    parameter int BLK_BITS = 3,
    parameter int WIN_CYC  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_prog,
    input  logic                prog_d7,
    input  logic                cmd_blk_erase,
    input  logic [BLK_BITS-1:0] cmd_blk,
    input  logic                cmd_chip_erase,
    input  logic                cmd_suspend,
    input  logic                cmd_resume,
    input  logic                cmd_reset,
    input  logic                op_done,
    input  logic                op_fail,
    input  logic                rd_stb,
    input  logic [BLK_BITS-1:0] rd_blk,
    input  logic [7:0]          arr_data,
    output logic [7:0]          dq
);
    fsm_e st_q, st_d;

    logic             pd7_q;
    logic             ers_q;
    logic             chip_q;
    logic             rd_q;
    logic [BUS_W-1:0] dq_q, stat_d;

    logic rd_edge;
    logic go_prog, go_blk_first, go_blk_add, go_chip;
    logic win_exp, hit;
    logic t6_q, t2_q, f6, f2, n6, n2;

    assign rd_edge      = rd_stb && !rd_q;
    assign go_prog      = (st_q == ST_IDLE) && cmd_prog;
    assign go_blk_first = (st_q == ST_IDLE) && !cmd_prog && cmd_blk_erase;
    assign go_chip      = (st_q == ST_IDLE) && !cmd_prog && !cmd_blk_erase && cmd_chip_erase;
    assign go_blk_add   = (st_q == ST_EWIN) && cmd_blk_erase;

    flsts_win_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go_blk_first || go_blk_add),
        .run     (st_q == ST_EWIN),
        .expired (win_exp)
    );

    flsts_erase_map #(
        .BLK_BITS (BLK_BITS)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .first   (go_blk_first),
        .add     (go_blk_add),
        .set_all (go_chip),
        .cmd_blk (cmd_blk),
        .rd_blk  (rd_blk),
        .hit     (hit)
    );

    // Toggle qualification: bit 6 follows any running or failed operation,
    // bit 2 only reads that land in the erase set.
    always_comb begin
        f6 = 1'b0;
        f2 = 1'b0;
        unique case (st_q)
            ST_IDLE:  begin f6 = 1'b0;    f2 = 1'b0;           end
            ST_PROG:  begin f6 = rd_edge; f2 = 1'b0;           end
            ST_EWIN:  begin f6 = rd_edge; f2 = rd_edge && hit; end
            ST_ERASE: begin f6 = rd_edge; f2 = rd_edge && hit; end
            ST_SUSP:  begin f6 = 1'b0;    f2 = rd_edge && hit; end
            ST_FAULT: begin f6 = rd_edge; f2 = rd_edge && hit && ers_q; end
            default:  begin f6 = 1'b0;    f2 = 1'b0;           end
        endcase
    end

    flsts_toggle u_t6 (.clk(clk), .rst_n(rst_n), .flip(f6), .q(t6_q));
    flsts_toggle u_t2 (.clk(clk), .rst_n(rst_n), .flip(f2), .q(t2_q));

    assign n6 = t6_q ^ f6;
    assign n2 = t2_q ^ f2;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go_prog)           st_d = ST_PROG;
                else if (go_blk_first) st_d = ST_EWIN;
                else if (go_chip)      st_d = ST_ERASE;
            end
            ST_PROG: begin
                if (op_fail)      st_d = ST_FAULT;
                else if (op_done) st_d = ST_IDLE;
            end
            ST_EWIN: begin
                if (win_exp) st_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (op_fail)                      st_d = ST_FAULT;
                else if (op_done)                 st_d = ST_IDLE;
                else if (cmd_suspend && !chip_q)  st_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (cmd_resume) st_d = ST_ERASE;
            end
            ST_FAULT: begin
                if (cmd_reset) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pd7_q  <= 1'b0;
            ers_q  <= 1'b0;
            chip_q <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            rd_q <= rd_stb;
            if (go_prog) begin
                pd7_q <= prog_d7;
                ers_q <= 1'b0;
            end
            if (go_blk_first) begin
                ers_q  <= 1'b1;
                chip_q <= 1'b0;
            end
            if (go_chip) begin
                ers_q  <= 1'b1;
                chip_q <= 1'b1;
            end
        end
    end

    // Status byte assembly
    always_comb begin
        stat_d = arr_data;
        unique case (st_q)
            ST_IDLE:  stat_d = arr_data;
            ST_PROG:  stat_d = {~pd7_q, n6, 1'b0, 1'b0, 1'b0, n2, 2'b00};
            ST_EWIN:  stat_d = {1'b0,   n6, 1'b0, 1'b0, 1'b0, n2, 2'b00};
            ST_ERASE: stat_d = {1'b0,   n6, 1'b0, 1'b0, 1'b1, n2, 2'b00};
            ST_SUSP:  stat_d = hit ? {1'b1, n6, 1'b0, 1'b0, 1'b1, n2, 2'b00} : arr_data;
            ST_FAULT: stat_d = {(ers_q ? 1'b0 : ~pd7_q), n6, 1'b1, 1'b0, ers_q, n2, 2'b00};
            default:  stat_d = arr_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else if (rd_edge) begin
            dq_q <= stat_d;
        end
    end

    assign dq = dq_q;

endmodule

// File: rtl/flsts_chk.sv
module flsts_chk
    import flsts_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       cmd_reset,
    input logic       op_done,
    input logic       op_fail,
    input fsm_e       st,
    input logic       tgl6,
    input logic [7:0] dq
);
    logic rd_prev;
    logic rd_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_stb;
    end

    assign rd_rise = rd_stb && !rd_prev;

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && st == ST_FAULT |=> dq[5]); // R6

    AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && (st == ST_PROG || st == ST_EWIN || st == ST_ERASE) |=> !dq[5]); // R6

    AST_FAULT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_FAULT && !cmd_reset |=> st == ST_FAULT); // R6

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && st != ST_IDLE && st != ST_SUSP |=> (dq & 8'h13) == 8'h00); // R9

    AST_WIN_DQ3_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && st == ST_EWIN |=> !dq[3]); // R7

    AST_ERASE_DQ3_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && st == ST_ERASE |=> dq[3] && !dq[7]); // R3

    AST_DQ6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && (st == ST_PROG || st == ST_ERASE) |=> dq[6] == !$past(tgl6)); // R5

    AST_SUSP_DQ6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise && st == ST_SUSP |=> $stable(tgl6)); // R5

    AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_rise |=> $stable(dq)); // R11

    AST_PROG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_PROG && !op_done && !op_fail |=> st == ST_PROG); // R10

endmodule

bind flash_status_unit flsts_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .cmd_reset (cmd_reset),
    .op_done   (op_done),
    .op_fail   (op_fail),
    .st        (st_q),
    .tgl6      (t6_q),
    .dq        (dq)
);

// File: tb/sim_flash_status_unit.sv
module sim_flash_status_unit;

    localparam int BB  = 3;
    localparam int WIN = 8;

    localparam logic [3:0] OP_RD   = 4'd0;
    localparam logic [3:0] OP_PROG = 4'd1;
    localparam logic [3:0] OP_BERS = 4'd2;
    localparam logic [3:0] OP_CERS = 4'd3;
    localparam logic [3:0] OP_SUSP = 4'd4;
    localparam logic [3:0] OP_RES  = 4'd5;
    localparam logic [3:0] OP_RST  = 4'd6;
    localparam logic [3:0] OP_DONE = 4'd7;
    localparam logic [3:0] OP_FAIL = 4'd8;
    localparam logic [3:0] OP_WAIT = 4'd9;

    localparam int NV = 40;
    // {req[3:0], op[3:0], addr[15:0], val[7:0], exp[7:0]}; array byte = addr[7:0]^5A
    localparam logic [39:0] VEC [0:NV-1] = '{
        {4'd1,  OP_RD,   16'h0012, 8'h00, 8'h48},  // R1 idle array read
        {4'd0,  OP_PROG, 16'h0100, 8'hA5, 8'h00},
        {4'd2,  OP_RD,   16'h0100, 8'h00, 8'h40},  // R2 inverted bit 7
        {4'd5,  OP_RD,   16'h0100, 8'h00, 8'h00},  // R5 dq6 flips
        {4'd0,  OP_DONE, 16'h0000, 8'h00, 8'h00},
        {4'd1,  OP_RD,   16'h0100, 8'h00, 8'h5A},  // R1 back to array
        {4'd0,  OP_BERS, 16'h4000, 8'h00, 8'h00},
        {4'd0,  OP_WAIT, 16'h0000, 8'd5,  8'h00},
        {4'd0,  OP_BERS, 16'hA000, 8'h00, 8'h00},
        {4'd0,  OP_WAIT, 16'h0000, 8'd5,  8'h00},
        {4'd7,  OP_RD,   16'h4010, 8'h00, 8'h44},  // R7 window restarted, dq3=0
        {4'd0,  OP_WAIT, 16'h0000, 8'd10, 8'h00},
        {4'd8,  OP_RD,   16'h6000, 8'h00, 8'h0C},  // R8 other block: dq2 holds
        {4'd8,  OP_RD,   16'hA004, 8'h00, 8'h48},  // R8 added block: dq2 flips
        {4'd0,  OP_SUSP, 16'h0000, 8'h00, 8'h00},
        {4'd3,  OP_RD,   16'h4000, 8'h00, 8'hCC},  // R3 suspended block
        {4'd5,  OP_RD,   16'h4000, 8'h00, 8'hC8},  // R5 dq6 holds in suspend
        {4'd4,  OP_RD,   16'h2034, 8'h00, 8'h6E},  // R4 array data in suspend
        {4'd0,  OP_RES,  16'h0000, 8'h00, 8'h00},
        {4'd3,  OP_RD,   16'h4000, 8'h00, 8'h0C},  // R3 erase resumed
        {4'd0,  OP_FAIL, 16'h0000, 8'h00, 8'h00},
        {4'd6,  OP_RD,   16'h4000, 8'h00, 8'h68},  // R6 erase fault
        {4'd8,  OP_RD,   16'h4000, 8'h00, 8'h2C},  // R8 faulty block flips
        {4'd8,  OP_RD,   16'h0000, 8'h00, 8'h6C},  // R8 other block holds
        {4'd0,  OP_RST,  16'h0000, 8'h00, 8'h00},
        {4'd6,  OP_RD,   16'h0000, 8'h00, 8'h5A},  // R6 cleared by read/reset
        {4'd0,  OP_CERS, 16'h0000, 8'h00, 8'h00},
        {4'd7,  OP_RD,   16'h0000, 8'h00, 8'h08},  // R7 chip erase, no window
        {4'd0,  OP_SUSP, 16'h0000, 8'h00, 8'h00},
        {4'd10, OP_RD,   16'hE000, 8'h00, 8'h4C},  // R10 suspend ignored, chip erase
        {4'd0,  OP_DONE, 16'h0000, 8'h00, 8'h00},
        {4'd1,  OP_RD,   16'hE000, 8'h00, 8'h5A},  // R1
        {4'd0,  OP_PROG, 16'h0200, 8'h35, 8'h00},
        {4'd2,  OP_RD,   16'h0200, 8'h00, 8'h84},  // R2 bit 7 inverted from 0
        {4'd0,  OP_BERS, 16'h4000, 8'h00, 8'h00},
        {4'd10, OP_RD,   16'h0200, 8'h00, 8'hC4},  // R10 erase ignored in program
        {4'd0,  OP_FAIL, 16'h0000, 8'h00, 8'h00},
        {4'd9,  OP_RD,   16'h0200, 8'h00, 8'hA4},  // R9 program fault byte
        {4'd0,  OP_RST,  16'h0000, 8'h00, 8'h00},
        {4'd1,  OP_RD,   16'h0200, 8'h00, 8'h5A}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_prog = 1'b0, prog_d7 = 1'b0, cmd_blk_erase = 1'b0;
    logic        cmd_chip_erase = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0;
    logic        cmd_reset = 1'b0, op_done = 1'b0, op_fail = 1'b0, rd_stb = 1'b0;
    logic [15:0] cmd_addr = 16'h0, rd_addr = 16'h0;
    logic [7:0]  arr_data;
    logic [7:0]  dq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign arr_data = rd_addr[7:0] ^ 8'h5A;

    flash_status_unit #(.BLK_BITS(BB), .WIN_CYC(WIN)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_prog       (cmd_prog),
        .prog_d7        (prog_d7),
        .cmd_blk_erase  (cmd_blk_erase),
        .cmd_blk        (cmd_addr[15:13]),
        .cmd_chip_erase (cmd_chip_erase),
        .cmd_suspend    (cmd_suspend),
        .cmd_resume     (cmd_resume),
        .cmd_reset      (cmd_reset),
        .op_done        (op_done),
        .op_fail        (op_fail),
        .rd_stb         (rd_stb),
        .rd_blk         (rd_addr[15:13]),
        .arr_data       (arr_data),
        .dq             (dq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                       input logic [7:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s: dq actual %02h expected %02h (mask %02h)", req, act, exp, mask);
        end
    endtask

    task automatic pulse(input logic [3:0] op, input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        cmd_addr = a;
        prog_d7  = v[7];
        case (op)
            OP_PROG: cmd_prog       = 1'b1;
            OP_BERS: cmd_blk_erase  = 1'b1;
            OP_CERS: cmd_chip_erase = 1'b1;
            OP_SUSP: cmd_suspend    = 1'b1;
            OP_RES:  cmd_resume     = 1'b1;
            OP_RST:  cmd_reset      = 1'b1;
            OP_DONE: op_done        = 1'b1;
            OP_FAIL: op_fail        = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        cmd_prog = 1'b0; cmd_blk_erase = 1'b0; cmd_chip_erase = 1'b0;
        cmd_suspend = 1'b0; cmd_resume = 1'b0; cmd_reset = 1'b0;
        op_done = 1'b0; op_fail = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input int hold, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        rd_stb  = 1'b1;
        repeat (hold) @(negedge clk);
        v = dq;
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, v1, v2, v3;
        repeat (3) @(negedge clk);
        chk("R1 reset value", dq, 8'h00, 8'hFF);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] req, op;
            logic [15:0] a;
            logic [7:0] val, exp;
            {req, op, a, val, exp} = VEC[i];
            if (op == OP_RD) begin
                rd(a, 1, v);
                checks++;
                if (v !== exp) begin
                    errors++;
                    $display("FAIL R%0d vector %0d: dq actual %02h expected %02h", req, i, v, exp);
                end
            end else if (op == OP_WAIT) begin
                repeat (int'(val)) @(negedge clk);
            end else begin
                pulse(op, a, val);
            end
        end

        // R10: done pulse while suspended has no effect
        pulse(OP_BERS, 16'h2000, 8'h00);
        repeat (WIN + 4) @(negedge clk);
        pulse(OP_SUSP, 16'h0000, 8'h00);
        pulse(OP_DONE, 16'h0000, 8'h00);
        rd(16'h2000, 1, v);
        chk("R10 done ignored in suspend", v, 8'h88, 8'hBB);
        pulse(OP_RES, 16'h0000, 8'h00);
        pulse(OP_DONE, 16'h0000, 8'h00);
        rd(16'h2000, 1, v);
        chk("R1 array after erase done", v, 8'h5A, 8'hFF);

        // R11: long strobe is one read, dq holds without a strobe
        pulse(OP_PROG, 16'h0300, 8'h80);
        rd(16'h0300, 1, v1);
        rd(16'h0300, 4, v2);
        rd(16'h0300, 1, v3);
        chk("R11 one flip per long strobe", {7'd0, v2[6]}, {7'd0, ~v1[6]}, 8'h01);
        chk("R11 next read flips again", {7'd0, v3[6]}, {7'd0, ~v2[6]}, 8'h01);
        chk("R2 program bit 7 of 1", v3, 8'h00, 8'hB8);
        rd_addr = 16'hE0FF;
        repeat (4) @(negedge clk);
        chk("R11 dq held without strobe", dq, v3, 8'hFF);
        pulse(OP_DONE, 16'h0000, 8'h00);

        // R7: window then erase
        pulse(OP_BERS, 16'h8000, 8'h00);
        rd(16'h8000, 1, v);
        chk("R7 dq3 low in window", v, 8'h00, 8'h88);
        repeat (WIN + 2) @(negedge clk);
        rd(16'h8000, 1, v);
        chk("R7 dq3 high after window", v, 8'h08, 8'h88);

        // R1: reset in the middle of an erase
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset clears dq", dq, 8'h00, 8'hFF);
        rst_n = 1'b1;
        rd(16'h8011, 1, v);
        chk("R1 idle after reset", v, 8'h11 ^ 8'h5A, 8'hFF);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule